// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Block

This block is the register file that sits between software and the transmit and receive descriptor engines of an Ethernet DMA. Software reaches it through a simple word-addressed bus. A write takes effect on the clock edge where `busWrEn` is high. A read is combinational from `busAddr`. The block stores the bus mode word, the two descriptor-list base addresses, the control word and the interrupt mask. It also keeps the two current-descriptor pointers, which the engines advance and which a base write rewinds.

The engines report completion and buffer-starvation events as one-cycle pulses. The block collects these pulses into sticky status bits, together with normal and abnormal summary bits. Software clears the status bits by writing ones to them. A single level interrupt is raised whenever a status bit is set and its mask bit is set.

Toward the engines, the block produces four signals. A write to the kick location produces a one-cycle transmit poll request. Setting bit 0 of the bus mode word produces a one-cycle soft-reset request. Two control bits are forwarded as level enables.

Top module: `dma_csr_top`

## Requirements
- R1: After reset every stored register reads 0, `irq` is low, and `txPollKick`, `swResetPulse`, `rxEnable` and `txStart` are low.
- R2: Word offsets are: 0 bus mode, 1 poll kick, 2 receive list base, 3 transmit list base, 4 status, 5 control, 6 interrupt mask, 7 current receive pointer, 8 current transmit pointer, 9 version. A write to status clears each bit written as 1 and keeps each bit written as 0.
- R3: Status bits and the events that set them are: bit 0 and bit 16 on `txDoneEv`; bit 2 and bit 15 on `txUnavailEv`; bit 6 and bit 16 on `rxDoneEv`; bit 7 and bit 15 on `rxUnavailEv`. All other status bits always read 0.
- R4: When an event pulse and a status clear hit the same bit on the same edge, the bit ends up set.
- R5: `irq` is high exactly when (status AND interrupt mask) is nonzero. It follows the registers from the cycle after the write or event edge.
- R6: A write to a list base also loads the matching current pointer with the same value. If an engine load of that pointer happens on the same edge, the base write wins.
- R7: When `rxCurLoad` or `txCurLoad` is high, the matching current pointer takes `rxCurNext` or `txCurNext` on that edge.
- R8: A write to offset 1 stores nothing and reads back 0. It drives `txPollKick` high for exactly the one cycle after the write edge.
- R9: Bus mode stores the written word with bit 0 forced to 0. A write with bit 0 set drives `swResetPulse` high for the one cycle after the write edge.
- R10: The control word is stored whole. `rxEnable` follows control bit 1 and `txStart` follows control bit 13.
- R11: Offset 9 always reads 0x1012, and writes to it have no effect.
- R12: Offsets 10 to 15 read 0, and writes to them change no register.
- R13: The current pointers cannot be written from the bus: a write to offset 7 or 8 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Word address for reads and writes |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| txDoneEv | input | 1 | Transmit frame completed pulse |
| txUnavailEv | input | 1 | Transmit descriptor not owned pulse |
| rxDoneEv | input | 1 | Receive frame completed pulse |
| rxUnavailEv | input | 1 | Receive descriptor not owned pulse |
| rxCurLoad | input | 1 | Receive engine pointer update strobe |
| rxCurNext | input | DATA_W | New receive pointer value |
| txCurLoad | input | 1 | Transmit engine pointer update strobe |
| txCurNext | input | DATA_W | New transmit pointer value |
| rxCurPtr | output | DATA_W | Current receive descriptor pointer |
| txCurPtr | output | DATA_W | Current transmit descriptor pointer |
| irq | output | 1 | Level interrupt |
| txPollKick | output | 1 | One-cycle transmit poll request |
| swResetPulse | output | 1 | One-cycle soft-reset request |
| rxEnable | output | 1 | Receive enable level |
| txStart | output | 1 | Transmit start level |

## Verification
The bench targets the edge where an event and a write-one-to-clear land together. A design where the clear wins would lose the event, so the status bit would read 0 and the interrupt would stay low.

It also lands a list-base write on the same edge as an engine pointer load. Giving the engine priority would leave the pointer at the engine's value instead of the rewound base.

Further directed cases cover these faults:
- a kick that leaks into storage, or a pulse that lasts two cycles;
- a bus mode bit 0 that reads back 1;
- writes to the version, pointer or unmapped offsets that alias onto real registers.

Random mixes of writes, events and pointer loads then compare every readable offset and every output against a reference model.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int unsigned OFF_BUSMODE = 0;
  localparam int unsigned OFF_KICK    = 1;
  localparam int unsigned OFF_RXBASE  = 2;
  localparam int unsigned OFF_TXBASE  = 3;
  localparam int unsigned OFF_STATUS  = 4;
  localparam int unsigned OFF_CONTROL = 5;
  localparam int unsigned OFF_INTEN   = 6;
  localparam int unsigned OFF_RXCUR   = 7;
  localparam int unsigned OFF_TXCUR   = 8;
  localparam int unsigned OFF_VERSION = 9;

  localparam int unsigned ST_TXDONE  = 0;
  localparam int unsigned ST_TXUNAV  = 2;
  localparam int unsigned ST_RXDONE  = 6;
  localparam int unsigned ST_RXUNAV  = 7;
  localparam int unsigned ST_ABNSUM  = 15;
  localparam int unsigned ST_NORMSUM = 16;

  localparam int unsigned CTL_RXEN  = 1;
  localparam int unsigned CTL_TXGO  = 13;

  localparam logic [31:0] VERSION_WORD = 32'h0000_1012;

  typedef struct packed {
    logic busMode;
    logic kick;
    logic rxBase;
    logic txBase;
    logic status;
    logic control;
    logic intEn;
  } csrStrobes_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_BUSMODE, RD_RXBASE, RD_TXBASE, RD_STATUS,
    RD_CONTROL, RD_INTEN, RD_RXCUR, RD_TXCUR, RD_VERSION
  } rdSel_t;

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output csrStrobes_t       strobes,
  output rdSel_t            rdSel
);

  always_comb begin
    strobes = '0;
    rdSel   = RD_NONE;
    unique case (busAddr)
      ADDR_W'(OFF_BUSMODE): begin strobes.busMode = busWrEn; rdSel = RD_BUSMODE; end
      ADDR_W'(OFF_KICK):    begin strobes.kick    = busWrEn; rdSel = RD_NONE;    end
      ADDR_W'(OFF_RXBASE):  begin strobes.rxBase  = busWrEn; rdSel = RD_RXBASE;  end
      ADDR_W'(OFF_TXBASE):  begin strobes.txBase  = busWrEn; rdSel = RD_TXBASE;  end
      ADDR_W'(OFF_STATUS):  begin strobes.status  = busWrEn; rdSel = RD_STATUS;  end
      ADDR_W'(OFF_CONTROL): begin strobes.control = busWrEn; rdSel = RD_CONTROL; end
      ADDR_W'(OFF_INTEN):   begin strobes.intEn   = busWrEn; rdSel = RD_INTEN;   end
      ADDR_W'(OFF_RXCUR):   rdSel = RD_RXCUR;
      ADDR_W'(OFF_TXCUR):   rdSel = RD_TXCUR;
      ADDR_W'(OFF_VERSION): rdSel = RD_VERSION;
      default:              rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/dma_csr_dp.sv
module dma_csr_dp
  import dma_csr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CHAN = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  csrStrobes_t                    strobes,
  input  rdSel_t                         rdSel,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [3:0]                     events,
  input  logic [NUM_CHAN-1:0]            curLoad,
  input  logic [NUM_CHAN-1:0][DATA_W-1:0] curNext,
  output logic [NUM_CHAN-1:0][DATA_W-1:0] curPtr,
  output logic [DATA_W-1:0]              rdData,
  output logic [DATA_W-1:0]              statusQ,
  output logic [DATA_W-1:0]              intEnQ,
  output logic                           irq,
  output logic                           txPollKick,
  output logic                           swResetPulse,
  output logic                           rxEnable,
  output logic                           txStart
);

  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << ST_TXDONE) | (DATA_W'(1) << ST_TXUNAV) |
    (DATA_W'(1) << ST_RXDONE) | (DATA_W'(1) << ST_RXUNAV) |
    (DATA_W'(1) << ST_ABNSUM) | (DATA_W'(1) << ST_NORMSUM);

  logic [DATA_W-1:0] busModeQ, controlQ;
  logic [NUM_CHAN-1:0][DATA_W-1:0] baseQ;
  logic [NUM_CHAN-1:0] baseWr;
  logic [DATA_W-1:0] setVec, clrVec, statusNext;

  assign baseWr = {strobes.txBase, strobes.rxBase};

  generate
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : gChan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          baseQ[ch]  <= '0;
          curPtr[ch] <= '0;
        end else if (baseWr[ch]) begin
          baseQ[ch]  <= wrData;
          curPtr[ch] <= wrData;
        end else if (curLoad[ch]) begin
          curPtr[ch] <= curNext[ch];
        end
      end
    end
  endgenerate

  always_comb begin
    setVec = '0;
    if (events[0]) begin setVec[ST_TXDONE] = 1'b1; setVec[ST_NORMSUM] = 1'b1; end
    if (events[1]) begin setVec[ST_TXUNAV] = 1'b1; setVec[ST_ABNSUM]  = 1'b1; end
    if (events[2]) begin setVec[ST_RXDONE] = 1'b1; setVec[ST_NORMSUM] = 1'b1; end
    if (events[3]) begin setVec[ST_RXUNAV] = 1'b1; setVec[ST_ABNSUM]  = 1'b1; end
    clrVec     = strobes.status ? wrData : '0;
    statusNext = ((statusQ & ~clrVec) | setVec) & STATUS_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ      <= '0;
      busModeQ     <= '0;
      controlQ     <= '0;
      intEnQ       <= '0;
      txPollKick   <= 1'b0;
      swResetPulse <= 1'b0;
    end else begin
      statusQ      <= statusNext;
      txPollKick   <= strobes.kick;
      swResetPulse <= strobes.busMode & wrData[0];
      if (strobes.busMode) busModeQ <= {wrData[DATA_W-1:1], 1'b0};
      if (strobes.control) controlQ <= wrData;
      if (strobes.intEn)   intEnQ   <= wrData;
    end
  end

  assign irq      = |(statusQ & intEnQ);
  assign rxEnable = controlQ[CTL_RXEN];
  assign txStart  = controlQ[CTL_TXGO];

  always_comb begin
    unique case (rdSel)
      RD_BUSMODE: rdData = busModeQ;
      RD_RXBASE:  rdData = baseQ[0];
      RD_TXBASE:  rdData = baseQ[1];
      RD_STATUS:  rdData = statusQ;
      RD_CONTROL: rdData = controlQ;
      RD_INTEN:   rdData = intEnQ;
      RD_RXCUR:   rdData = curPtr[0];
      RD_TXCUR:   rdData = curPtr[1];
      RD_VERSION: rdData = DATA_W'(VERSION_WORD);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              txDoneEv,
  input  logic              txUnavailEv,
  input  logic              rxDoneEv,
  input  logic              rxUnavailEv,
  input  logic              rxCurLoad,
  input  logic [DATA_W-1:0] rxCurNext,
  input  logic              txCurLoad,
  input  logic [DATA_W-1:0] txCurNext,
  output logic [DATA_W-1:0] rxCurPtr,
  output logic [DATA_W-1:0] txCurPtr,
  output logic              irq,
  output logic              txPollKick,
  output logic              swResetPulse,
  output logic              rxEnable,
  output logic              txStart
);

  localparam int unsigned NUM_CHAN = 2;

  csrStrobes_t strobes;
  rdSel_t      rdSel;
  logic [DATA_W-1:0] statusQ, intEnQ;
  logic [NUM_CHAN-1:0][DATA_W-1:0] curPtr;
  logic [NUM_CHAN-1:0][DATA_W-1:0] curNext;

  assign curNext  = {txCurNext, rxCurNext};
  assign rxCurPtr = curPtr[0];
  assign txCurPtr = curPtr[1];

  dma_csr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  dma_csr_dp #(.DATA_W(DATA_W), .NUM_CHAN(NUM_CHAN)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .rdSel        (rdSel),
    .wrData       (busWrData),
    .events       ({rxUnavailEv, rxDoneEv, txUnavailEv, txDoneEv}),
    .curLoad      ({txCurLoad, rxCurLoad}),
    .curNext      (curNext),
    .curPtr       (curPtr),
    .rdData       (busRdData),
    .statusQ      (statusQ),
    .intEnQ       (intEnQ),
    .irq          (irq),
    .txPollKick   (txPollKick),
    .swResetPulse (swResetPulse),
    .rxEnable     (rxEnable),
    .txStart      (txStart)
  );

endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              txUnavailEv,
  input logic              rxDoneEv,
  input logic [DATA_W-1:0] rxCurPtr,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] intEnQ,
  input logic              irq,
  input logic              txPollKick
);

  a_r4_rx_event_sticks: assert property (@(posedge clk) disable iff (!rstN)
    $past(rxDoneEv) |-> (statusQ[ST_RXDONE] && statusQ[ST_NORMSUM]));

  a_r4_tx_unavail_sticks: assert property (@(posedge clk) disable iff (!rstN)
    $past(txUnavailEv) |-> (statusQ[ST_TXUNAV] && statusQ[ST_ABNSUM]));

  a_r5_irq_needs_cause: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != '0 && intEnQ != '0));

  a_r5_irq_masked_low: assert property (@(posedge clk) disable iff (!rstN)
    (intEnQ == '0) |-> !irq);

  a_r6_base_reload: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWrEn && busAddr == ADDR_W'(OFF_RXBASE)) |-> (rxCurPtr == $past(busWrData)));

  a_r8_kick_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    txPollKick |-> $past(busWrEn && busAddr == ADDR_W'(OFF_KICK)));

  a_r8_write_gives_kick: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWrEn && busAddr == ADDR_W'(OFF_KICK)) |-> txPollKick);

  a_r9_busmode_bit0_low: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_BUSMODE)) |-> !busRdData[0]);

  a_r11_version_const: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_VERSION)) |-> (busRdData == DATA_W'(VERSION_WORD)));

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr > ADDR_W'(OFF_VERSION)) |-> (busRdData == '0));

endmodule

bind dma_csr_top dma_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busWrData   (busWrData),
  .busRdData   (busRdData),
  .txUnavailEv (txUnavailEv),
  .rxDoneEv    (rxDoneEv),
  .rxCurPtr    (rxCurPtr),
  .statusQ     (statusQ),
  .intEnQ      (intEnQ),
  .irq         (irq),
  .txPollKick  (txPollKick)
);

// File: tb/dma_csr_top_tb_top.sv
module dma_csr_top_tb_top;

  localparam time HALF = 10ns;
  localparam logic [31:0] SMASK = 32'h0001_80C5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic txDoneEv = 0, txUnavailEv = 0, rxDoneEv = 0, rxUnavailEv = 0;
  logic rxCurLoad = 0, txCurLoad = 0;
  logic [31:0] rxCurNext = '0, txCurNext = '0;
  logic [31:0] rxCurPtr, txCurPtr;
  logic irq, txPollKick, swResetPulse, rxEnable, txStart;

  always #(HALF) clk = ~clk;

  dma_csr_top dut_i (.*);

  int vecs = 0;
  int errs = 0;

  logic [31:0] mBusMode = 0, mRxBase = 0, mTxBase = 0, mStatus = 0;
  logic [31:0] mCtrl = 0, mIntEn = 0, mRxCur = 0, mTxCur = 0;
  logic expKick = 0, expSw = 0;

  function automatic logic [31:0] modelRead(logic [3:0] a);
    case (a)
      4'd0: return mBusMode;
      4'd2: return mRxBase;
      4'd3: return mTxBase;
      4'd4: return mStatus;
      4'd5: return mCtrl;
      4'd6: return mIntEn;
      4'd7: return mRxCur;
      4'd8: return mTxCur;
      4'd9: return 32'h1012;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic modelUpdate(bit wr, logic [3:0] a, logic [31:0] d, logic [3:0] ev,
                             bit rl, logic [31:0] rn, bit tl, logic [31:0] tn);
    logic [31:0] s;
    s = mStatus & ~((wr && a == 4'd4) ? d : 32'h0);
    if (ev[0]) s = s | 32'h0001_0001;
    if (ev[1]) s = s | 32'h0000_8004;
    if (ev[2]) s = s | 32'h0001_0040;
    if (ev[3]) s = s | 32'h0000_8080;
    mStatus = s & SMASK;
    if (wr && a == 4'd2) begin mRxBase = d; mRxCur = d; end else if (rl) mRxCur = rn;
    if (wr && a == 4'd3) begin mTxBase = d; mTxCur = d; end else if (tl) mTxCur = tn;
    if (wr && a == 4'd0) mBusMode = d & ~32'h1;
    if (wr && a == 4'd5) mCtrl = d;
    if (wr && a == 4'd6) mIntEn = d;
    expKick = wr && a == 4'd1;
    expSw   = wr && a == 4'd0 && d[0];
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(bit wr, logic [3:0] a, logic [31:0] d, logic [3:0] ev,
                      bit rl = 0, logic [31:0] rn = 0, bit tl = 0, logic [31:0] tn = 0);
    busWrEn = wr; busAddr = a; busWrData = d;
    {rxUnavailEv, rxDoneEv, txUnavailEv, txDoneEv} = ev;
    rxCurLoad = rl; rxCurNext = rn; txCurLoad = tl; txCurNext = tn;
    @(posedge clk);
    modelUpdate(wr, a, d, ev, rl, rn, tl, tn);
    @(negedge clk);
    busWrEn = 0; {rxUnavailEv, rxDoneEv, txUnavailEv, txDoneEv} = 4'h0;
    rxCurLoad = 0; txCurLoad = 0;
    chk("R8 kick pulse", 32'(txPollKick), 32'(expKick));
    chk("R9 soft reset pulse", 32'(swResetPulse), 32'(expSw));
    chk("R5 irq", 32'(irq), 32'(|(mStatus & mIntEn)));
    chk("R10 rxEnable", 32'(rxEnable), 32'(mCtrl[1]));
    chk("R10 txStart", 32'(txStart), 32'(mCtrl[13]));
    chk("R7 rx pointer", rxCurPtr, mRxCur);
    chk("R7 tx pointer", txCurPtr, mTxCur);
  endtask

  task automatic rd(string req, logic [3:0] a);
    busWrEn = 0; busAddr = a;
    #1;
    chk(req, busRdData, modelRead(a));
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errs++;
    $display("FAIL watchdog expired got=%h exp=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1221));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 version, R12 unmapped
    for (int a = 0; a < 16; a++) rd("R1 reset read", 4'(a));
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 kick after reset", 32'(txPollKick), 32'h0);
    chk("R1 enables after reset", 32'({rxEnable, txStart}), 32'h0);

    // R3 and R5: rx done sets bit 6 and bit 16
    step(1, 4'd6, 32'hFFFF_FFFF, 4'h0);
    step(0, 4'd0, 32'h0, 4'b0100);
    rd("R3 rx done bits", 4'd4);
    chk("R3 status value", busRdData, 32'h0001_0040);
    // R2: clear bit 6 only
    step(1, 4'd4, 32'h0000_0040, 4'h0);
    rd("R2 partial clear", 4'd4);
    chk("R5 irq stays high", 32'(irq), 32'h1);
    step(1, 4'd4, 32'h0001_0000, 4'h0);
    chk("R5 irq falls", 32'(irq), 32'h0);
    // R4: clear all while tx unavailable fires
    step(1, 4'd4, 32'hFFFF_FFFF, 4'b0010);
    rd("R4 set beats clear", 4'd4);
    chk("R4 status value", busRdData, 32'h0000_8004);
    step(0, 4'd0, 32'h0, 4'b1001);
    rd("R3 tx done and rx unavailable", 4'd4);
    // R5 mask
    step(1, 4'd6, 32'h0000_0001, 4'h0);
    step(1, 4'd4, 32'h0000_0001, 4'h0);
    chk("R5 masked irq low", 32'(irq), 32'h0);

    // R6: base write beats engine load
    step(1, 4'd2, 32'h0000_1000, 4'h0, 1, 32'h0000_2000);
    chk("R6 rx pointer reloaded", rxCurPtr, 32'h0000_1000);
    step(0, 4'd0, 32'h0, 4'h0, 1, 32'h0000_1040);
    chk("R7 rx pointer advanced", rxCurPtr, 32'h0000_1040);
    step(1, 4'd3, 32'h0000_3000, 4'h0, 0, 0, 1, 32'h0000_5000);
    chk("R6 tx pointer reloaded", txCurPtr, 32'h0000_3000);
    // R13 pointers are not bus-writable
    step(1, 4'd7, 32'hDEAD_BEEF, 4'h0);
    step(1, 4'd8, 32'hDEAD_BEEF, 4'h0);
    rd("R13 rx pointer unchanged", 4'd7);
    rd("R13 tx pointer unchanged", 4'd8);

    // R8 kick
    step(1, 4'd1, 32'hFFFF_FFFF, 4'h0);
    rd("R8 kick reads zero", 4'd1);
    step(0, 4'd0, 32'h0, 4'h0);
    // R9 bus mode
    step(1, 4'd0, 32'h0000_00FF, 4'h0);
    rd("R9 bus mode", 4'd0);
    chk("R9 bus mode value", busRdData, 32'h0000_00FE);
    // R10 control
    step(1, 4'd5, 32'h0000_2002, 4'h0);
    chk("R10 both enables", 32'({rxEnable, txStart}), 32'h3);
    // R11 version write ignored
    step(1, 4'd9, 32'h0, 4'h0);
    rd("R11 version", 4'd9);
    // R12 unmapped write
    step(1, 4'd12, 32'h1234_5678, 4'h0);
    rd("R12 unmapped read", 4'd12);
    for (int a = 0; a < 10; a++) rd("R12 registers unchanged", 4'(a));

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      logic [3:0] ev;
      bit wr;
      a  = 4'($urandom_range(0, 15));
      d  = $urandom();
      if ($urandom_range(0, 3) == 0) d = d | 32'h0001_80C5;
      ev = 4'($urandom() & $urandom());
      wr = $urandom_range(0, 2) != 0;
      step(wr, a, d, ev, $urandom_range(0, 3) == 0, $urandom(),
           $urandom_range(0, 3) == 0, $urandom());
      rd("R2 random read", 4'($urandom_range(0, 15)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule